// File: doc/BRIEF.md
# Sticky Flash Status Register

This block keeps the 8-bit status byte that a flash write state machine reports to the host. The sequencer sends it per-bit set and clear events, suspend and resume pulses, and a command-sequence-error pulse. The host's clear-status command and the device reset act on it as well. Error flags are sticky. Once raised, only the explicit clear command or a reset lowers them. This lets software run a batch of program or erase operations and check for failures once at the end.

When status read mode is active, the byte is driven onto the low half of a 16-bit read bus and the high half is held at zero. The block does not show the value live. It captures the byte when a read access opens, which happens when both the chip-enable and output-enable strobes are low, at whichever of the two falls later. The captured value is held for the whole access. A polling host must close the access and open a new one to see a change such as completion.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the status byte is 0x80: ready set, every other bit clear.
- R2: Bit 0 always reads 0, even when a set event targets it. During a status read, bus bits 15:8 read 0x00.
- R3: A sequencer set event on any of bits 7..1 (`set_i`) sets that bit on the next clock edge.
- R4: A sequencer clear event (`clr_i`) is honoured only on bit 7 (ready), bit 6 (erase suspended) and bit 2 (program suspended). Clear events on bits 5, 4, 3, 1 and 0 have no effect.
- R5: The error bits are bit 5 (erase error), bit 4 (program error), bit 3 (supply-low abort) and bit 1 (locked-sector abort). They stay set until `clr_cmd_i` or reset. `clr_cmd_i` clears exactly these four bits.
- R6: An erase suspend sets bits 7 and 6. A program suspend sets bits 7 and 2. A resume clears bits 6, 2 and 7.
- R7: A command-sequence-error pulse sets bits 5, 4, 3 and 1 together.
- R8: The bus value is captured on the edge where the later of `ce_ni` and `oe_ni` falls, and it stays frozen while both remain low. A status change during an open access appears only after a new access.
- R9: `rd_valid_o` is 1 and the bus carries status only while an access is open and `stat_mode_i` is 1. Otherwise the bus reads 0.
- R10: A set event or suspend on a bit in the same cycle as a clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous device reset |
| set_i | input | 8 | Per-bit set events from the sequencer |
| clr_i | input | 8 | Per-bit clear events from the sequencer |
| clr_cmd_i | input | 1 | Clear-status command pulse |
| seq_err_i | input | 1 | Command-sequence-error pulse |
| susp_erase_i | input | 1 | Erase suspended pulse |
| susp_prog_i | input | 1 | Program suspended pulse |
| resume_i | input | 1 | Resume pulse |
| stat_mode_i | input | 1 | Status read mode active |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_data_o | output | 16 | Read bus |
| rd_valid_o | output | 1 | Read bus carries captured status |

## Verification
A sticky bit lost by mistake would show as a missing error flag on the next status read, one access after the event or after an unrelated sequencer clear. A wrong capture point would show as a bus value that changes mid-access, or that misses an event raised between the two strobe falls. Each scenario reads the byte back through a complete strobe access, so any corruption of the held state appears at the bus within two cycles of opening the access.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int unsigned SR_W = 8;

  localparam int unsigned B_RDY  = 7;
  localparam int unsigned B_ESUS = 6;
  localparam int unsigned B_EERR = 5;
  localparam int unsigned B_PERR = 4;
  localparam int unsigned B_VLOW = 3;
  localparam int unsigned B_PSUS = 2;
  localparam int unsigned B_LOCK = 1;

  localparam logic [SR_W-1:0] ERR_MASK  = (8'd1 << B_EERR) | (8'd1 << B_PERR) |
                                          (8'd1 << B_VLOW) | (8'd1 << B_LOCK);
  localparam logic [SR_W-1:0] SCLR_MASK = (8'd1 << B_RDY) | (8'd1 << B_ESUS) |
                                          (8'd1 << B_PSUS);
  localparam logic [SR_W-1:0] SSET_MASK = 8'hFE;
  localparam logic [SR_W-1:0] RST_VAL   = 8'd1 << B_RDY;
endpackage

// File: rtl/fsr_bits.sv
module fsr_bits
  import flash_status_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SR_W-1:0] set_i,
  input  logic [SR_W-1:0] clr_i,
  input  logic            clr_cmd_i,
  input  logic            seq_err_i,
  input  logic            susp_erase_i,
  input  logic            susp_prog_i,
  input  logic            resume_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q, sr_d, clr_all, set_all;

  // clears first, sets last: set wins on collision
  always_comb begin
    clr_all = clr_i & SCLR_MASK;
    if (clr_cmd_i) clr_all = clr_all | ERR_MASK;
    if (resume_i)  clr_all = clr_all | SCLR_MASK;
    set_all = set_i;
    if (seq_err_i)    set_all = set_all | ERR_MASK;
    if (susp_erase_i) set_all = set_all | (8'd1 << B_RDY) | (8'd1 << B_ESUS);
    if (susp_prog_i)  set_all = set_all | (8'd1 << B_RDY) | (8'd1 << B_PSUS);
    sr_d = ((sr_q & ~clr_all) | set_all) & SSET_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= RST_VAL;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_q[0] == 1'b0);
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_cmd_i |=> ((($past(sr_q) & ERR_MASK) & ~sr_q) == '0));
  assert_err_only_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd_i && !seq_err_i && ((set_i & ERR_MASK) == '0)) |=> ((sr_q & ERR_MASK) == '0));
  assert_esus_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_erase_i |=> (sr_q[B_RDY] && sr_q[B_ESUS]));
  assert_psus_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_prog_i |=> (sr_q[B_RDY] && sr_q[B_PSUS]));
  assert_seq_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_i |=> ((sr_q & ERR_MASK) == ERR_MASK));
  assert_set_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(set_i) & SSET_MASK) & ~sr_q) == '0));
endmodule

// File: rtl/fsr_rd_latch.sv
module fsr_rd_latch
  import flash_status_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SR_W-1:0]  sr_i,
  input  logic             ce_ni,
  input  logic             oe_ni,
  input  logic             stat_mode_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  localparam int unsigned PAD_W = BUS_W - SR_W;

  logic            acc, acc_q;
  logic [SR_W-1:0] hold_q;

  assign acc = !ce_ni && !oe_ni;

  // capture once per access, on the later strobe fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      acc_q <= acc;
      if (acc && !acc_q) hold_q <= sr_i;
    end
  end

  assign rd_valid_o = acc_q && acc && stat_mode_i;
  assign rd_data_o  = rd_valid_o ? {{PAD_W{1'b0}}, hold_q} : '0;

  assert_hold_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && acc_q) |=> $stable(hold_q));
  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BUS_W-1:SR_W] == '0);
  assert_idle_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_status_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       set_i,
  input  logic [7:0]       clr_i,
  input  logic             clr_cmd_i,
  input  logic             seq_err_i,
  input  logic             susp_erase_i,
  input  logic             susp_prog_i,
  input  logic             resume_i,
  input  logic             stat_mode_i,
  input  logic             ce_ni,
  input  logic             oe_ni,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic [SR_W-1:0] sr;

  fsr_bits u_bits (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_i),
    .clr_i        (clr_i),
    .clr_cmd_i    (clr_cmd_i),
    .seq_err_i    (seq_err_i),
    .susp_erase_i (susp_erase_i),
    .susp_prog_i  (susp_prog_i),
    .resume_i     (resume_i),
    .sr_o         (sr)
  );

  fsr_rd_latch #(.BUS_W(BUS_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sr_i        (sr),
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .stat_mode_i (stat_mode_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o)
  );
endmodule

// File: tb/flash_status_reg_tb.sv
module flash_status_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  set_i = '0, clr_i = '0;
  logic        clr_cmd_i = 0, seq_err_i = 0, susp_erase_i = 0, susp_prog_i = 0, resume_i = 0;
  logic        stat_mode_i = 1'b1, ce_ni = 1'b1, oe_ni = 1'b1;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk_i = ~clk_i;

  flash_status_reg dut_i (.*);

  task automatic chk(string req, logic [16:0] got, logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(output logic [16:0] v);
    @(negedge clk_i); ce_ni = 0; oe_ni = 0;
    @(negedge clk_i); v = {rd_valid_o, rd_data_o};
    ce_ni = 1; oe_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic rd_chk(string req, logic [7:0] exp);
    logic [16:0] v;
    rd(v);
    chk(req, v, {1'b1, 8'h00, exp});
  endtask

  task automatic ev(logic [7:0] s, logic [7:0] c, bit cc, bit se, bit sue, bit sup, bit res);
    @(negedge clk_i);
    set_i = s; clr_i = c; clr_cmd_i = cc; seq_err_i = se;
    susp_erase_i = sue; susp_prog_i = sup; resume_i = res;
    @(negedge clk_i);
    set_i = 0; clr_i = 0; clr_cmd_i = 0; seq_err_i = 0;
    susp_erase_i = 0; susp_prog_i = 0; resume_i = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 reset value", 8'h80);
  endtask

  task automatic t_set_clear();
    ev(8'h16, 0, 0, 0, 0, 0, 0);
    rd_chk("R3 set bits 4,2,1", 8'h96);
    ev(0, 8'hFF, 0, 0, 0, 0, 0);
    rd_chk("R4 seq clear only 7,6,2", 8'h12);
    ev(0, 0, 1, 0, 0, 0, 0);
    rd_chk("R5 clear cmd", 8'h00);
    ev(8'h81, 0, 0, 0, 0, 0, 0);
    rd_chk("R2 bit0 not settable", 8'h80);
    ev(0, 8'h80, 0, 0, 0, 0, 0);
    ev(8'h80, 8'h80, 0, 0, 0, 0, 0);
    rd_chk("R10 set wins over clear", 8'h80);
  endtask

  task automatic t_sticky();
    ev(0, 0, 0, 1, 0, 0, 0);
    rd_chk("R7 seq error sets 5,4,3,1", 8'hBA);
    ev(0, 8'hFF, 0, 0, 0, 0, 0);
    rd_chk("R5 errors survive seq clear", 8'h3A);
    ev(8'h80, 0, 0, 0, 0, 0, 0);
    rd_chk("R5 errors survive next op", 8'hBA);
    ev(8'h10, 0, 1, 0, 0, 0, 0);
    rd_chk("R10 set beats clear cmd", 8'h90);
    ev(0, 0, 1, 0, 0, 0, 0);
    rd_chk("R5 clear cmd leaves ready", 8'h80);
  endtask

  task automatic t_suspend();
    ev(0, 8'h80, 0, 0, 0, 0, 0);
    ev(0, 0, 0, 0, 1, 0, 0);
    rd_chk("R6 erase suspend", 8'hC0);
    ev(0, 0, 0, 0, 0, 0, 1);
    rd_chk("R6 resume after erase", 8'h00);
    ev(0, 0, 0, 0, 0, 1, 0);
    rd_chk("R6 program suspend", 8'h84);
    ev(0, 0, 0, 0, 0, 0, 1);
    rd_chk("R6 resume after program", 8'h00);
    ev(8'h80, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_latch();
    logic [16:0] v;
    @(negedge clk_i); ce_ni = 0; oe_ni = 0;
    @(negedge clk_i); chk("R8 open access", {rd_valid_o, rd_data_o}, 17'h10080);
    set_i = 8'h20;
    @(negedge clk_i); set_i = 0;
    @(negedge clk_i); chk("R8 frozen mid access", {rd_valid_o, rd_data_o}, 17'h10080);
    ce_ni = 1; oe_ni = 1;
    @(negedge clk_i);
    rd_chk("R8 new access sees change", 8'hA0);
    // oe falls first, ce later; event in between must be captured
    oe_ni = 0;
    @(negedge clk_i); chk("R9 half strobe idle", {rd_valid_o, rd_data_o}, 17'h0);
    set_i = 8'h02;
    @(negedge clk_i); set_i = 0; ce_ni = 0;
    @(negedge clk_i); chk("R8 later strobe captures", {rd_valid_o, rd_data_o}, 17'h100A2);
    ce_ni = 1; oe_ni = 1;
    @(negedge clk_i);
    ev(0, 0, 1, 0, 0, 0, 0);
    stat_mode_i = 0;
    rd(v);
    chk("R9 no status outside mode", v, 17'h0);
    stat_mode_i = 1;
    chk("R9 idle bus", {rd_valid_o, rd_data_o}, 17'h0);
    rd_chk("R9 mode back on", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_set_clear();
    t_sticky();
    t_suspend();
    t_latch();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule